// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block models a field-programmable two-plane logic array. A set of binary inputs feeds an AND plane that forms a number of product terms, and an OR plane that gathers any subset of those terms into each output. Both planes sit in configuration registers. Any product term can feed any number of outputs, so a term that two outputs share is built once.

Software or a boot sequencer raises the configure-mode input and loads one product-term row per write strobe. A row carries the literal codes for that term and its output-connection bits. When configure mode drops, the outputs follow the inputs combinationally from the next clock cycle on. No clock lies in the path from input to output. After reset the array is in its erased state: every crossing in both planes is connected, so every term is forced to 0 and every output reads 0.

Top module: `pla_core`

## Requirements
- R1: After reset every crossing is connected: every AND literal code is 2'b11 and every OR bit is 1. In run mode all outputs read 0 for every input value.
- R2: Each input k takes a 2-bit code at bits [2k+1:2k] of the AND row. Bit 2k selects the input used true and bit 2k+1 selects it used complemented. A product term is the AND of all its selected literals.
- R3: A literal code of 2'b11 forces the product term to 0 whatever the inputs are.
- R4: A product term whose literal codes are all 2'b00 evaluates to 1.
- R5: An output with no connected product term reads 0. OR-row bit j connects the term to output j.
- R6: One product term may be connected to several outputs at once and drives each of them.
- R7: A write strobe while configure mode is low is ignored and leaves both planes unchanged.
- R8: While configure mode is high all outputs read 0. After configure mode drops, outputs stay 0 until the next rising clock edge and are valid from then on.
- R9: A write in configure mode replaces only the row at the given term address. All other rows keep their contents.
- R10: Loaded with the five-term reference personality, with A, B and C on inputs 0, 1 and 2, the outputs equal F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A for every input value.
- R11: In run mode the outputs respond to an input change within the same clock cycle, with no clock edge in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration registers and the mode register |
| rst_ni | input | 1 | Active-low asynchronous reset; erases both planes |
| cfg_mode_i | input | 1 | High selects configure mode |
| wr_en_i | input | 1 | Row write strobe, honoured only in configure mode |
| wr_addr_i | input | 3 | Product-term row address |
| wr_and_i | input | 8 | Literal codes for the row, 2 bits per input |
| wr_or_i | input | 4 | Output-connection bits for the row |
| in_i | input | 4 | Logic inputs |
| out_o | output | 4 | Sum-of-products outputs |

## Verification
A row write takes effect at the rising edge where the strobe is sampled. Run-mode outputs are combinational, so the bench drives every input on the falling edge and samples one nanosecond later, before the next rising edge. That makes any response to an input change a same-cycle response. The mode transition is the one registered result. Right after configure mode drops, the bench samples once before the next rising edge and expects zeros, then samples once after that edge and expects valid logic. The checks for ignored writes read the outputs after the stray strobe's edge has passed, using an input value where the stray row would have changed the result.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_SKIP  = 2'b00,
    LIT_TRUE  = 2'b01,
    LIT_COMP  = 2'b10,
    LIT_NEVER = 2'b11
  } lit_e;

  function automatic logic lit_pass(lit_e code, logic x);
    unique case (code)
      LIT_SKIP:  lit_pass = 1'b1;
      LIT_TRUE:  lit_pass = x;
      LIT_COMP:  lit_pass = ~x;
      default:   lit_pass = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pla_store.sv
module pla_store #(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 8,
  parameter int N_OUT   = 4,
  localparam int AW     = (N_TERMS > 1) ? $clog2(N_TERMS) : 1,
  localparam int AND_W  = 2 * N_IN
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [AND_W-1:0]           and_row_i,
  input  logic [N_OUT-1:0]           or_row_i,
  output logic [N_TERMS*AND_W-1:0]   and_plane_o,
  output logic [N_TERMS*N_OUT-1:0]   or_plane_o
);

  for (genvar t = 0; t < N_TERMS; t++) begin : g_row
    logic row_sel;
    assign row_sel = we_i && (int'(addr_i) == t);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        and_plane_o[t*AND_W +: AND_W] <= '1;  // erased: all connected
        or_plane_o[t*N_OUT +: N_OUT]  <= '1;
      end else if (row_sel) begin
        and_plane_o[t*AND_W +: AND_W] <= and_row_i;
        or_plane_o[t*N_OUT +: N_OUT]  <= or_row_i;
      end
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 8,
  localparam int AND_W  = 2 * N_IN
) (
  input  logic [N_IN-1:0]            in_i,
  input  logic [N_TERMS*AND_W-1:0]   and_plane_i,
  output logic [N_TERMS-1:0]         term_o
);

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    always_comb begin
      logic hit;
      hit = 1'b1;
      for (int k = 0; k < N_IN; k++) begin
        hit &= lit_pass(lit_e'(and_plane_i[t*AND_W + 2*k +: 2]), in_i[k]);
      end
      term_o[t] = hit;
    end
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERMS = 8,
  parameter int N_OUT   = 4
) (
  input  logic [N_TERMS-1:0]         term_i,
  input  logic [N_TERMS*N_OUT-1:0]   or_plane_i,
  output logic [N_OUT-1:0]           sum_o
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int t = 0; t < N_TERMS; t++) begin
        acc |= term_i[t] & or_plane_i[t*N_OUT + o];
      end
      sum_o[o] = acc;
    end
  end

endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 8,
  parameter int N_OUT   = 4,
  localparam int AW     = (N_TERMS > 1) ? $clog2(N_TERMS) : 1,
  localparam int AND_W  = 2 * N_IN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mode_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [AND_W-1:0]  wr_and_i,
  input  logic [N_OUT-1:0]  wr_or_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_OUT-1:0]  out_o
);

  logic [N_TERMS*AND_W-1:0] and_plane;
  logic [N_TERMS*N_OUT-1:0] or_plane;
  logic [N_TERMS-1:0]       term;
  logic [N_OUT-1:0]         sum;
  logic                     run_q;
  logic                     we;

  assign we = cfg_mode_i && wr_en_i && (int'(wr_addr_i) < N_TERMS);

  pla_store #(.N_IN(N_IN), .N_TERMS(N_TERMS), .N_OUT(N_OUT)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we),
    .addr_i      (wr_addr_i),
    .and_row_i   (wr_and_i),
    .or_row_i    (wr_or_i),
    .and_plane_o (and_plane),
    .or_plane_o  (or_plane)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_and (
    .in_i        (in_i),
    .and_plane_i (and_plane),
    .term_o      (term)
  );

  pla_or_plane #(.N_TERMS(N_TERMS), .N_OUT(N_OUT)) u_or (
    .term_i     (term),
    .or_plane_i (or_plane),
    .sum_o      (sum)
  );

  // outputs open one edge after configure mode drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= ~cfg_mode_i;
  end

  assign out_o = (run_q && !cfg_mode_i) ? sum : '0;

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
  parameter int N_IN    = 4,
  parameter int N_TERMS = 8,
  parameter int N_OUT   = 4,
  localparam int AW     = (N_TERMS > 1) ? $clog2(N_TERMS) : 1,
  localparam int AND_W  = 2 * N_IN
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cfg_mode_i,
  input logic                     wr_en_i,
  input logic [AW-1:0]            wr_addr_i,
  input logic [AND_W-1:0]         wr_and_i,
  input logic [N_OUT-1:0]         wr_or_i,
  input logic [N_OUT-1:0]         out_o,
  input logic [N_TERMS*AND_W-1:0] and_plane,
  input logic [N_TERMS*N_OUT-1:0] or_plane
);

  logic [N_OUT-1:0] col_empty;
  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      col_empty[o] = 1'b1;
      for (int t = 0; t < N_TERMS; t++) col_empty[o] &= ~or_plane[t*N_OUT + o];
    end
  end

  a_r8_cfg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mode_i |-> out_o == '0);

  a_r8_first_run_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_mode_i) |-> out_o == '0);

  a_r7_and_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_i |=> $stable(and_plane));

  a_r7_or_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_i |=> $stable(or_plane));

  a_r9_row_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i && wr_en_i && int'(wr_addr_i) < N_TERMS) |=>
      (and_plane[int'($past(wr_addr_i))*AND_W +: AND_W] == $past(wr_and_i)) &&
      (or_plane[int'($past(wr_addr_i))*N_OUT +: N_OUT] == $past(wr_or_i)));

  a_r5_empty_col_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o & col_empty) == '0);

endmodule

bind pla_core pla_core_chk #(.N_IN(N_IN), .N_TERMS(N_TERMS), .N_OUT(N_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_mode_i (cfg_mode_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_and_i   (wr_and_i),
  .wr_or_i    (wr_or_i),
  .out_o      (out_o),
  .and_plane  (and_plane),
  .or_plane   (or_plane)
);

// File: tb/pla_core_bench.sv
module pla_core_bench;

  localparam int N_IN = 4, N_TERMS = 8, N_OUT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_and = '0;
  logic [3:0] wr_or = '0;
  logic [3:0] in_v = '0;
  logic [3:0] out_v;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pla_core #(.N_IN(N_IN), .N_TERMS(N_TERMS), .N_OUT(N_OUT)) u_pla_core (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_and_i(wr_and), .wr_or_i(wr_or),
    .in_i(in_v), .out_o(out_v)
  );

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (in=%b)", req, got, exp, in_v);
    end
  endtask

  function automatic logic [3:0] ref_f(logic [3:0] x);
    logic a, b, c;
    a = x[0]; b = x[1]; c = x[2];
    ref_f[0] = a | (~b & ~c);
    ref_f[1] = (a & ~c) | (a & b);
    ref_f[2] = (~b & ~c) | (a & b);
    ref_f[3] = (~b & c) | a;
  endfunction

  task automatic drive_in(logic [3:0] v);
    @(negedge clk);
    in_v = v;
    #1;
  endtask

  task automatic write_row(logic [2:0] a, logic [7:0] andb, logic [3:0] orb);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_and = andb; wr_or = orb;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enter_cfg();
    @(negedge clk);
    cfg = 1'b1;
  endtask

  task automatic leave_cfg();
    @(negedge clk);
    cfg = 1'b0;
    #1;
    check("R8 before reopen", out_v, 4'b0000);
    @(posedge clk);
    #1;
  endtask

  task automatic load_reference();
    enter_cfg();
    write_row(3'd0, 8'b0000_0001, 4'b1001); // A        -> F0,F3
    write_row(3'd1, 8'b0010_1000, 4'b0101); // B'C'     -> F0,F2
    write_row(3'd2, 8'b0010_0001, 4'b0010); // AC'      -> F1
    write_row(3'd3, 8'b0000_0101, 4'b0110); // AB       -> F1,F2
    write_row(3'd4, 8'b0001_1000, 4'b1000); // B'C      -> F3
    // rows 5..7 stay erased (forced 0)
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    for (int v = 0; v < 16; v += 5) begin
      drive_in(4'(v));
      check("R1 erased array", out_v, 4'b0000);
    end
  endtask

  task automatic t_reference();
    load_reference();
    drive_in(4'b0000);
    check("R8 held in cfg", out_v, 4'b0000);
    leave_cfg();
    check("R8 valid after reopen", out_v, ref_f(in_v));
    for (int v = 0; v < 16; v++) begin
      drive_in(4'(v));
      check("R10 R11 R2 reference", out_v, ref_f(4'(v)));
    end
    drive_in(4'b0000); // B'C' shared by F0 and F2
    check("R6 shared term", out_v, 4'b0101);
  endtask

  task automatic t_ignore();
    drive_in(4'b0110); // reference gives 0000 here
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd5; wr_and = 8'h00; wr_or = 4'b1111;
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk); #1;
    check("R7 run-mode write ignored", out_v, 4'b0000);
    drive_in(4'b0001);
    check("R7 array intact", out_v, ref_f(4'b0001));
  endtask

  task automatic t_corners();
    enter_cfg();
    for (int t = 0; t < N_TERMS; t++) write_row(3'(t), 8'h00, 4'b0000);
    write_row(3'd0, 8'b0000_0011, 4'b0001); // conflicting literal on input 0
    write_row(3'd1, 8'b0000_0000, 4'b0010); // empty term
    leave_cfg();
    for (int v = 0; v < 16; v += 3) begin
      drive_in(4'(v));
      check("R3 conflict forces 0", out_v & 4'b0001, 4'b0000);
      check("R4 empty term is 1", out_v & 4'b0010, 4'b0010);
      check("R5 unconnected outputs", out_v & 4'b1100, 4'b0000);
    end
    enter_cfg();
    write_row(3'd2, 8'b0000_1000, 4'b0100); // B' -> out2
    leave_cfg();
    for (int v = 0; v < 4; v++) begin
      drive_in(4'(v));
      check("R9 new row", out_v, {1'b0, ~in_v[1], 2'b10});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reference();
    t_ignore();
    t_corners();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule